// File: doc/BRIEF.md
# Register-Budgeted Wavefront Slot Scheduler

This block keeps track of the wavefronts resident on one SIMD unit and picks which of them runs next. A wavefront is a group of 64 work items that share one program counter, and each resident wavefront occupies one of a fixed number of slots. A launch request names a wave and states how many registers per lane it needs. The request is admitted only if a slot is free and the shared per-lane register budget still covers it. Because slots and registers are both limited, fewer waves fit as each wave asks for more registers: with a 256-register budget, 128 registers per wave admit 2 waves, 84 admit 3, 64 admit 4, and 25 or fewer admit all 10 slots.

Each cycle the block offers one resident wave that is not waiting on memory. It searches round-robin, starting from the slot after the last wave that was taken. A wave that issues a memory access is marked as waiting and is skipped until its memory response arrives. A completion pulse retires a wave, which returns its registers and slot to the pool.

Launch is decided in the cycle it is presented: there is no holding. Each request gets either an accept pulse or a reject pulse. The issue side is a valid/ready stream. `issue_valid` is high whenever some wave is ready, and the offered wave advances the round-robin order only on a cycle where `issue_valid` and `issue_ready` are both high. While `issue_ready` is low, the offer may change as waves become waiting, resume or complete.

Top module: `wave_slot_sched`

## Requirements
- R1: At most NUM_SLOTS (10) waves are resident. A launch presented while every slot is occupied is rejected, even when the register budget would cover it.
- R2: At most one wave is offered per cycle. `issue_slot` and `issue_wave_id` name a resident wave and the ID it was launched with.
- R3: A wave marked waiting by `wait_set` on its slot is not offered, and the next ready slot in round-robin order is offered instead. `mem_resp` on that slot makes it selectable again from the next cycle.
- R4: A launch is accepted only if its register count plus the registers held by resident waves is at most REG_BUDGET (256). Occupancy is therefore min(10, 256 / regs): 128 admits 2, 84 admits 3, 64 admits 4, 26 admits 9 and 25 admits 10.
- R5: A launch asking for 0 registers, or for more than MAX_REGS (128), is always rejected.
- R6: A rejected launch pulses `launch_reject` in the same cycle, never together with `launch_accept`, and changes no slot or budget state.
- R7: An accepted launch pulses `launch_accept` in the cycle it is presented. It takes the lowest-numbered free slot, which `launch_slot` reports.
- R8: Selection is round-robin. After reset the search starts at slot 0. After a handshake on slot s, the search starts at slot s+1 modulo NUM_SLOTS. Without a handshake the starting point does not move.
- R9: In the cycle of a completion pulse on slot s, the registers of slot s already count as free for a launch in that same cycle, but slot s cannot be reused until the following cycle. The completing wave is not offered in its completion cycle.
- R10: `issue_valid` is low in any cycle in which no resident wave is ready.
- R11: After reset no wave is resident, `issue_valid` is low, and the full budget is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request present this cycle |
| launch_wave_id | input | ID_W | Wave identifier of the request |
| launch_regs | input | REQ_W | Registers per lane requested |
| launch_accept | output | 1 | Request admitted this cycle |
| launch_reject | output | 1 | Request refused this cycle |
| launch_slot | output | SLOT_W | Slot given to an admitted wave |
| wait_set | input | 1 | Mark the wave in `wait_slot` as waiting on memory |
| wait_slot | input | SLOT_W | Slot to mark waiting |
| mem_resp | input | 1 | Memory response for the wave in `resp_slot` |
| resp_slot | input | SLOT_W | Slot whose wait is cleared |
| done_valid | input | 1 | Wave in `done_slot` has completed |
| done_slot | input | SLOT_W | Slot being retired |
| issue_valid | output | 1 | A ready wave is offered |
| issue_ready | input | 1 | Consumer takes the offered wave |
| issue_slot | output | SLOT_W | Slot of the offered wave |
| issue_wave_id | output | ID_W | ID of the offered wave |

## Verification
The bench builds the block with its default parameters: 10 slots, a 256-register budget and a 128-register cap per wave, so REQ_W is 8 bits. With these values a full table of 10 slots can coexist with spare budget, which separates a refusal for lack of slots from a refusal for lack of registers. The 8-bit request field can also carry counts above the cap, such as 129 and 200. These parameters also make the listed occupancy points reachable, including the 25/26 boundary where a tenth wave stops fitting.

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int WS_SLOTS_DEFAULT  = 10;
  localparam int WS_BUDGET_DEFAULT = 256;
  localparam int WS_MAXREG_DEFAULT = 128;
  localparam int WS_ID_W_DEFAULT   = 6;

  typedef struct packed {
    logic resident;
    logic waiting;
  } slot_flags_t;
endpackage

// File: rtl/wsched_budget.sv
module wsched_budget #(
  parameter int REG_BUDGET = 256,
  parameter int MAX_REGS   = 128,
  parameter int REQ_W      = $clog2(2 * MAX_REGS),
  parameter int CNT_W      = $clog2(REG_BUDGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_regs,
  input  logic             have_free_slot,
  input  logic             rel_en,
  input  logic [REQ_W-1:0] rel_regs,
  output logic             accept,
  output logic             reject
);
  localparam int AW = CNT_W + 1;
  localparam logic [AW-1:0] BUDGET_V = AW'(REG_BUDGET);
  localparam logic [AW-1:0] MAXREG_V = AW'(MAX_REGS);

  logic [CNT_W-1:0] used_q;
  logic [AW-1:0]    req_ext, rel_ext, headroom, used_nxt;
  logic             size_ok, fits;

  always_comb begin
    req_ext  = AW'(req_regs);
    rel_ext  = rel_en ? AW'(rel_regs) : '0;
    headroom = BUDGET_V - AW'(used_q) + rel_ext;
    size_ok  = (req_ext != '0) && (req_ext <= MAXREG_V);
    fits     = req_ext <= headroom;
    accept   = req_valid && size_ok && fits && have_free_slot;
    reject   = req_valid && !accept;
    used_nxt = AW'(used_q) - rel_ext + (accept ? req_ext : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_nxt[CNT_W-1:0];
  end

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    AW'(used_q) <= BUDGET_V); // R4
  AST_ACC_REJ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject)); // R6
  AST_OVERSIZE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && AW'(req_regs) > MAXREG_V) |-> reject); // R5
  AST_REJECT_KEEPS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !rel_en) |=> used_q == $past(used_q)); // R6
endmodule

// File: rtl/wsched_slot_table.sv
module wsched_slot_table
  import wsched_pkg::*;
#(
  parameter int NUM_SLOTS = 10,
  parameter int ID_W      = 6,
  parameter int REQ_W     = 8,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic [REQ_W-1:0]  alloc_regs,
  input  logic              wait_set,
  input  logic [SLOT_W-1:0] wait_slot,
  input  logic              mem_resp,
  input  logic [SLOT_W-1:0] resp_slot,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ID_W-1:0]   rd_id,
  output logic              free_any,
  output logic [SLOT_W-1:0] free_slot,
  output logic [NUM_SLOTS-1:0] ready_vec,
  output logic              rel_en,
  output logic [REQ_W-1:0]  rel_regs
);
  slot_flags_t       flags [NUM_SLOTS];
  logic [ID_W-1:0]   ids   [NUM_SLOTS];
  logic [REQ_W-1:0]  regs  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] hit_done, hit_alloc, resident_vec;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit_wait, hit_resp;
    assign hit_done[g]     = done_valid && (done_slot == SLOT_W'(g));
    assign hit_alloc[g]    = alloc_en && (free_slot == SLOT_W'(g));
    assign hit_wait        = wait_set && (wait_slot == SLOT_W'(g));
    assign hit_resp        = mem_resp && (resp_slot == SLOT_W'(g));
    assign resident_vec[g] = flags[g].resident;
    assign ready_vec[g]    = flags[g].resident && !flags[g].waiting && !hit_done[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[g] <= '0;
        ids[g]   <= '0;
        regs[g]  <= '0;
      end else if (hit_done[g] && flags[g].resident) begin
        flags[g] <= '0;
        regs[g]  <= '0;
      end else if (hit_alloc[g]) begin
        flags[g].resident <= 1'b1;
        flags[g].waiting  <= 1'b0;
        ids[g]            <= alloc_id;
        regs[g]           <= alloc_regs;
      end else if (flags[g].resident) begin
        if (hit_wait)      flags[g].waiting <= 1'b1;
        else if (hit_resp) flags[g].waiting <= 1'b0;
      end
    end

    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_alloc[g] |-> !flags[g].resident); // R7
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_done[g] && flags[g].resident) |=> !flags[g].resident); // R9
  end

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!flags[i].resident) begin
        free_any  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    rel_en   = 1'b0;
    rel_regs = '0;
    rd_id    = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (hit_done[i] && flags[i].resident) begin
        rel_en   = 1'b1;
        rel_regs = regs[i];
      end
      if (rd_slot == SLOT_W'(i)) rd_id = ids[i];
    end
  end

  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> (resident_vec != '1)); // R1
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
  parameter int NUM_SLOTS = 10,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] req_vec,
  input  logic                 advance,
  output logic                 grant_valid,
  output logic [SLOT_W-1:0]    grant_idx,
  output logic [NUM_SLOTS-1:0] grant_oh
);
  logic [SLOT_W-1:0] last_q;
  int cand;

  always_comb begin
    grant_valid = 1'b0;
    grant_idx   = '0;
    grant_oh    = '0;
    cand        = 0;
    for (int off = 1; off <= NUM_SLOTS; off++) begin
      cand = (int'(last_q) + off) % NUM_SLOTS;
      if (!grant_valid && req_vec[cand]) begin
        grant_valid    = 1'b1;
        grant_idx      = SLOT_W'(cand);
        grant_oh[cand] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      last_q <= SLOT_W'(NUM_SLOTS - 1);
    else if (advance && grant_valid) last_q <= grant_idx;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh)); // R2
  AST_GRANT_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> req_vec[grant_idx]); // R3
  AST_IDLE_WHEN_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vec == '0) |-> !grant_valid); // R10
  AST_HOLD_WITHOUT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> last_q == $past(last_q)); // R8
endmodule

// File: rtl/wave_slot_sched.sv
module wave_slot_sched
  import wsched_pkg::*;
#(
  parameter int NUM_SLOTS  = WS_SLOTS_DEFAULT,
  parameter int REG_BUDGET = WS_BUDGET_DEFAULT,
  parameter int MAX_REGS   = WS_MAXREG_DEFAULT,
  parameter int ID_W       = WS_ID_W_DEFAULT,
  parameter int REQ_W      = $clog2(2 * MAX_REGS),
  parameter int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [ID_W-1:0]   launch_wave_id,
  input  logic [REQ_W-1:0]  launch_regs,
  output logic              launch_accept,
  output logic              launch_reject,
  output logic [SLOT_W-1:0] launch_slot,
  input  logic              wait_set,
  input  logic [SLOT_W-1:0] wait_slot,
  input  logic              mem_resp,
  input  logic [SLOT_W-1:0] resp_slot,
  input  logic              done_valid,
  input  logic [SLOT_W-1:0] done_slot,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [SLOT_W-1:0] issue_slot,
  output logic [ID_W-1:0]   issue_wave_id
);
  logic                 free_any, rel_en;
  logic [SLOT_W-1:0]    free_slot;
  logic [NUM_SLOTS-1:0] ready_vec, grant_oh;
  logic [REQ_W-1:0]     rel_regs;

  wsched_budget #(
    .REG_BUDGET(REG_BUDGET), .MAX_REGS(MAX_REGS), .REQ_W(REQ_W)
  ) u_budget (
    .clk(clk), .rst_n(rst_n),
    .req_valid(launch_valid), .req_regs(launch_regs),
    .have_free_slot(free_any),
    .rel_en(rel_en), .rel_regs(rel_regs),
    .accept(launch_accept), .reject(launch_reject)
  );

  wsched_slot_table #(
    .NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W), .REQ_W(REQ_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(launch_accept), .alloc_id(launch_wave_id), .alloc_regs(launch_regs),
    .wait_set(wait_set), .wait_slot(wait_slot),
    .mem_resp(mem_resp), .resp_slot(resp_slot),
    .done_valid(done_valid), .done_slot(done_slot),
    .rd_slot(issue_slot), .rd_id(issue_wave_id),
    .free_any(free_any), .free_slot(free_slot),
    .ready_vec(ready_vec),
    .rel_en(rel_en), .rel_regs(rel_regs)
  );

  wsched_rr_pick #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_pick (
    .clk(clk), .rst_n(rst_n),
    .req_vec(ready_vec), .advance(issue_ready),
    .grant_valid(issue_valid), .grant_idx(issue_slot), .grant_oh(grant_oh)
  );

  assign launch_slot = free_slot;

  AST_ACCEPT_HAS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    launch_accept |-> free_any); // R1
  AST_ISSUE_NOT_RETIRING: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && done_valid) |-> (issue_slot != done_slot)); // R9
endmodule

// File: tb/wave_slot_sched_tb.sv
module wave_slot_sched_tb;
  localparam int N = 10, BUD = 256, MAXR = 128, IDW = 6;
  localparam int RW = $clog2(2 * MAXR), SW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic launch_valid = 0, wait_set = 0, mem_resp = 0, done_valid = 0, issue_ready = 0;
  logic [IDW-1:0] launch_wave_id = '0;
  logic [RW-1:0]  launch_regs = '0;
  logic [SW-1:0]  wait_slot = '0, resp_slot = '0, done_slot = '0;
  logic launch_accept, launch_reject, issue_valid;
  logic [SW-1:0] launch_slot, issue_slot;
  logic [IDW-1:0] issue_wave_id;

  int checks = 0, failures = 0;
  bit finished = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  wave_slot_sched u_dut (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_wave_id(launch_wave_id), .launch_regs(launch_regs),
    .launch_accept(launch_accept), .launch_reject(launch_reject), .launch_slot(launch_slot),
    .wait_set(wait_set), .wait_slot(wait_slot), .mem_resp(mem_resp), .resp_slot(resp_slot),
    .done_valid(done_valid), .done_slot(done_slot),
    .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_slot(issue_slot), .issue_wave_id(issue_wave_id)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected {slot,id} for each handshake.
  always @(negedge clk) begin
    if (rst_n && issue_valid && issue_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R8 unexpected issue", int'(issue_slot), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(issue_slot) == (e >> 8), "R8 issue order", int'(issue_slot), e >> 8);
        check(int'(issue_wave_id) == (e & 255), "R2 issue id", int'(issue_wave_id), e & 255);
      end
    end
  end

  // Starts and ends at posedge+1.
  task automatic launch(input int id, input int regs, input bit exp_acc, input int exp_slot,
                        input bit dn, input int dslot, input string req);
    launch_valid = 1; launch_wave_id = IDW'(id); launch_regs = RW'(regs);
    done_valid = dn; done_slot = SW'(dslot);
    @(negedge clk);
    check(launch_accept == exp_acc, {req, " accept"}, int'(launch_accept), int'(exp_acc));
    check(launch_reject == !exp_acc, {req, " reject"}, int'(launch_reject), int'(!exp_acc));
    if (exp_acc) check(int'(launch_slot) == exp_slot, {req, " slot"}, int'(launch_slot), exp_slot);
    @(posedge clk); #1;
    launch_valid = 0; done_valid = 0;
  endtask

  task automatic retire(input int s);
    done_valid = 1; done_slot = SW'(s);
    @(posedge clk); #1;
    done_valid = 0;
  endtask

  task automatic mark_wait(input int s);
    wait_set = 1; wait_slot = SW'(s);
    @(posedge clk); #1;
    wait_set = 0;
  endtask

  task automatic respond(input int s);
    mem_resp = 1; resp_slot = SW'(s);
    @(posedge clk); #1;
    mem_resp = 0;
  endtask

  task automatic expect_issue(input int s, input int id);
    exp_q.push_back((s << 8) | id);
  endtask

  task automatic take(input int n);
    issue_ready = 1;
    repeat (n) @(posedge clk);
    #1 issue_ready = 0;
    check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(100000 * 10);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int occ[5] = '{84, 64, 25, 26, 128};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(issue_valid == 0, "R11 idle after reset", int'(issue_valid), 0);
    check(issue_valid == 0, "R10 nothing ready", int'(issue_valid), 0);
    @(posedge clk); #1;

    // R5: size limits
    launch(1, 129, 0, 0, 0, 0, "R5 regs=129");
    launch(1, 200, 0, 0, 0, 0, "R5 regs=200");
    launch(1, 0, 0, 0, 0, 0, "R5 regs=0");
    // R11/R4: full budget available, 128+128 fits
    launch(1, 128, 1, 0, 0, 0, "R11 full budget");
    launch(2, 128, 1, 1, 0, 0, "R4 second 128");
    launch(3, 1, 0, 0, 0, 0, "R4 budget exhausted");
    retire(1);
    // R6: earlier reject left no trace, slot 1 freed goes to lowest free
    launch(4, 128, 1, 1, 0, 0, "R6 state unchanged after reject");
    retire(0);
    retire(1);

    // R4 occupancy sweep
    foreach (occ[k]) begin
      int r, n;
      r = occ[k];
      n = BUD / r;
      if (n > N) n = N;
      for (int i = 0; i < n; i++) launch(20 + i, r, 1, i, 0, 0, "R4 occupancy fill");
      launch(40, r, 0, 0, 0, 0, "R4 occupancy limit");
      for (int i = 0; i < n; i++) retire(i);
    end

    // R1: slots full while budget has room
    for (int i = 0; i < N; i++) launch(i, 25, 1, i, 0, 0, "R7 lowest slot");
    launch(50, 1, 0, 0, 0, 0, "R1 slot limit");
    // R9: slot retiring this cycle not reusable yet
    launch(51, 1, 0, 0, 1, 3, "R9 slot not reused same cycle");
    launch(52, 1, 1, 3, 0, 0, "R9 slot free next cycle");
    for (int i = 0; i < N; i++) retire(i);

    // R9: registers freed in the completion cycle
    launch(1, 128, 1, 0, 0, 0, "R9 setup");
    launch(2, 128, 1, 1, 0, 0, "R9 setup");
    launch(3, 128, 1, 2, 1, 0, "R9 regs freed same cycle");
    retire(1);
    retire(2);

    // Issue stream
    launch(10, 8, 1, 0, 0, 0, "R7 issue setup");
    launch(11, 8, 1, 1, 0, 0, "R7 issue setup");
    launch(12, 8, 1, 2, 0, 0, "R7 issue setup");
    @(negedge clk);
    check(issue_valid == 1, "R8 offer after reset", int'(issue_valid), 1);
    check(int'(issue_slot) == 0, "R8 starts at slot 0", int'(issue_slot), 0);
    @(posedge clk); #1;
    expect_issue(0, 10); expect_issue(1, 11); expect_issue(2, 12); expect_issue(0, 10);
    take(4);
    mark_wait(1);
    expect_issue(2, 12); expect_issue(0, 10); expect_issue(2, 12);
    take(3); // R3 waiting slot skipped
    respond(1);
    expect_issue(0, 10); expect_issue(1, 11); expect_issue(2, 12);
    take(3); // R3 resumed after response
    mark_wait(0); mark_wait(1); mark_wait(2);
    @(negedge clk);
    check(issue_valid == 0, "R10 all waiting", int'(issue_valid), 0);
    @(posedge clk); #1;
    respond(2);
    // R9: completing wave not offered in its completion cycle
    done_valid = 1; done_slot = 2;
    @(negedge clk);
    check(issue_valid == 0, "R9 retiring wave hidden", int'(issue_valid), 0);
    @(posedge clk); #1;
    done_valid = 0;

    finished = 1;
    summary();
    $finish;
  end
endmodule